// File: doc/BRIEF.md
# Single-Wire Serial Debug Monitor

This block is a debug command engine that a host drives over one shared, half-duplex serial wire at a fixed bit rate. The host sends command bytes. The engine sends each byte back on the same wire so that the host can see whether it arrived intact. It then decodes two commands, a memory read and a memory write, each carrying a 16-bit address, and carries them out on a simple synchronous memory port.

Every byte on the wire is framed as 8N1: a low start bit, eight data bits least significant bit first, and a high stop bit. The wire idles high. The engine drives the wire only while it sends an echo or read data. At all other times it releases the wire, with the output enable low and the output value high.

Fixed gaps separate the phases, each measured in bit times:
- a 2-bit gap comes before every echo;
- an 11-bit cancel window follows the last byte of every command;
- a 2-bit gap comes before returned read data.

If the host holds the wire low for at least 10 bit times (a break) inside the cancel window, the command is dropped. In that case nothing is written and nothing is returned.

The state machine has eight named states:
- `ST_WAIT_BYTE`: waits for the next host byte.
- `ST_ECHO_GAP`: 2-bit gap before an echo.
- `ST_ECHO`: sends the echo.
- `ST_CANCEL`: 11-bit break window.
- `ST_WRITE`: one-cycle write strobe.
- `ST_RET_GAP`: 2-bit gap before returned data.
- `ST_FETCH`: read data is captured and sent out.
- `ST_RET`: returned byte on the wire.

Its transitions are named as follows:
- wait→echo-gap on a byte;
- wait→wait on a break;
- echo-gap→echo when the timer ends;
- echo→wait after an opcode or any non-final byte;
- echo→cancel after the last address byte of a read or the data byte of a write;
- cancel→wait on a break;
- cancel→write for a write;
- cancel→ret-gap for a read;
- write→wait;
- ret-gap→fetch, which issues the read strobe;
- fetch→ret;
- ret→wait when the byte is sent.

Top module: `swire_mon`

## Requirements
- R1: Bytes sent by the block use 8N1 framing: a start bit of 0, data bits LSB first, and a stop bit of 1, each CLKS_PER_BIT clocks long. `line_oe` is 1 only while a frame is being sent.
- R2: Every byte received from the host is echoed unchanged. The echo starts no earlier than 2 bit times after the byte's stop bit is sampled.
- R3: Opcode 0x4A followed by an address high byte and then an address low byte is a read. After the last echo and the 11-bit cancel window, and a further 2-bit gap, exactly one `mem_re` pulse is issued with that address. The byte returned one cycle later by `mem_rdata` is sent on the wire.
- R4: Opcode 0x49 followed by address high, address low and one data byte is a write. Each of the four bytes is echoed. Once the cancel window expires, exactly one single-cycle `mem_we` pulse is issued with that address and data.
- R5: After the last echo of a command, the block waits 11 bit times before acting. A break that completes in this window cancels the command: no strobe, no returned byte. The engine then waits for a new opcode.
- R6: A break is the line held low for at least 10 consecutive bit times. A break while a command is still being received aborts it, and no byte is reported for the break.
- R7: An opcode other than 0x4A or 0x49 is echoed and then ignored. It causes no memory access and no further output, and the engine waits for an opcode again.
- R8: The receiver is armed as soon as an echo ends, so a host byte that starts one bit time later is accepted.
- R9: `mem_we` and `mem_re` are never high together, and each is high for one cycle at a time.
- R10: After reset the wire is released (`line_oe`=0, `line_out`=1), no strobe is active, and the engine waits for an opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_in | input | 1 | Value seen on the shared wire |
| line_out | output | 1 | Value driven onto the wire when enabled |
| line_oe | output | 1 | Drive enable for the wire |
| mem_addr | output | 16 | Memory address, high byte then low byte of the command |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write strobe, one cycle |
| mem_re | output | 1 | Read strobe, data expected on the next cycle |
| mem_rdata | input | 8 | Read data, valid one cycle after `mem_re` |

## Verification
The assertions check, on every cycle:
- the two memory strobes never overlap, and each lasts a single cycle;
- every frame the block drives begins with a low start bit;
- the wire has been released for at least two bit times before any new frame;
- a read strobe is always followed by a frame start;
- a write strobe never coincides with a driven wire.

The echo values, the LSB-first bit order, and the exact lengths of the cancel window and return gap can only be shown by the bench's scenarios, because they depend on host traffic. The same holds for cancellation by a break, the abort of a half-received command, and the silence after an unknown opcode.

// File: rtl/swire_pkg.sv
package swire_pkg;
    localparam logic [7:0] OPC_READ  = 8'h4A;
    localparam logic [7:0] OPC_WRITE = 8'h49;
    localparam int GAP_BITS    = 2;
    localparam int WINDOW_BITS = 11;
    localparam int BREAK_BITS  = 10;

    typedef enum logic [2:0] {
        ST_WAIT_BYTE,
        ST_ECHO_GAP,
        ST_ECHO,
        ST_CANCEL,
        ST_WRITE,
        ST_RET_GAP,
        ST_FETCH,
        ST_RET
    } mon_state_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_HOLD
    } rx_state_e;
endpackage

// File: rtl/swire_rx.sv
module swire_rx
    import swire_pkg::*;
#(
    parameter int CLKS_PER_BIT = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       rx_in,
    output logic       byte_valid,
    output logic [7:0] byte_out,
    output logic       brk
);
    localparam int CNT_W   = $clog2(CLKS_PER_BIT);
    localparam int BRK_CYC = BREAK_BITS * CLKS_PER_BIT;
    localparam int RUN_W   = $clog2(BRK_CYC + 1);
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(CLKS_PER_BIT / 2 - 1);
    localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(CLKS_PER_BIT - 1);
    localparam logic [RUN_W-1:0] RUN_MAX   = RUN_W'(BRK_CYC);
    localparam logic [RUN_W-1:0] RUN_HIT   = RUN_W'(BRK_CYC - 1);

    logic            sync1, sync2;
    rx_state_e       st;
    logic [CNT_W-1:0] cnt;
    logic [2:0]      bit_idx;
    logic [7:0]      shreg;
    logic [RUN_W-1:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
        end else begin
            sync1 <= rx_in;
            sync2 <= sync1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st         <= RX_IDLE;
            cnt        <= '0;
            bit_idx    <= '0;
            shreg      <= '0;
            low_run    <= '0;
            byte_valid <= 1'b0;
            brk        <= 1'b0;
        end else if (!en) begin
            st         <= RX_IDLE;
            cnt        <= '0;
            bit_idx    <= '0;
            low_run    <= '0;
            byte_valid <= 1'b0;
            brk        <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            brk        <= 1'b0;
            if (sync2) begin
                low_run <= '0;
            end else if (low_run != RUN_MAX) begin
                low_run <= low_run + 1'b1;
                if (low_run == RUN_HIT) brk <= 1'b1;
            end
            unique case (st)
                RX_IDLE: begin
                    cnt <= '0;
                    if (!sync2) st <= RX_START;
                end
                RX_START: begin
                    if (cnt == HALF_LAST) begin
                        cnt     <= '0;
                        bit_idx <= '0;
                        st      <= sync2 ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (cnt == BIT_LAST) begin
                        cnt   <= '0;
                        shreg <= {sync2, shreg[7:1]};
                        if (bit_idx == 3'd7) st <= RX_STOP;
                        bit_idx <= bit_idx + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (cnt == BIT_LAST) begin
                        cnt <= '0;
                        if (sync2) begin
                            byte_valid <= 1'b1;
                            st         <= RX_IDLE;
                        end else begin
                            st <= RX_HOLD;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_HOLD: begin
                    if (sync2) st <= RX_IDLE;
                end
                default: st <= RX_IDLE;
            endcase
        end
    end

    assign byte_out = shreg;
endmodule

// File: rtl/swire_tx.sv
module swire_tx #(
    parameter int CLKS_PER_BIT = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] data,
    output logic       tx_out,
    output logic       tx_oe,
    output logic       done
);
    localparam int CNT_W = $clog2(CLKS_PER_BIT);
    localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(CLKS_PER_BIT - 1);

    logic             busy;
    logic [9:0]       frame;
    logic [3:0]       bits_left;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            frame     <= '1;
            bits_left <= '0;
            cnt       <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy      <= 1'b1;
                    frame     <= {1'b1, data, 1'b0};
                    bits_left <= 4'd9;
                    cnt       <= '0;
                end
            end else if (cnt == BIT_LAST) begin
                cnt <= '0;
                if (bits_left == 4'd0) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    frame     <= {1'b1, frame[9:1]};
                    bits_left <= bits_left - 1'b1;
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign tx_oe  = busy;
    assign tx_out = busy ? frame[0] : 1'b1;
endmodule

// File: rtl/swire_mon.sv
module swire_mon
    import swire_pkg::*;
#(
    parameter int CLKS_PER_BIT = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        line_in,
    output logic        line_out,
    output logic        line_oe,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    output logic        mem_we,
    output logic        mem_re,
    input  logic [7:0]  mem_rdata
);
    localparam int GAP_CYC = GAP_BITS * CLKS_PER_BIT;
    localparam int WIN_CYC = WINDOW_BITS * CLKS_PER_BIT;
    localparam int TMR_W   = $clog2(WIN_CYC + 1);
    localparam logic [TMR_W-1:0] GAP_LOAD = TMR_W'(GAP_CYC - 1);
    localparam logic [TMR_W-1:0] WIN_LOAD = TMR_W'(WIN_CYC - 1);

    mon_state_e       state, state_d;
    logic [TMR_W-1:0] timer;
    logic             tmr_done;
    logic [1:0]       idx, idx_d;
    logic             is_rd;
    logic [7:0]       cur_byte, addr_hi, addr_lo, wdata;

    logic       rx_en, rx_valid, rx_brk;
    logic [7:0] rx_byte;
    logic       tx_start, tx_done;
    logic [7:0] tx_byte;

    swire_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (rx_en),
        .rx_in      (line_in),
        .byte_valid (rx_valid),
        .byte_out   (rx_byte),
        .brk        (rx_brk)
    );

    swire_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (tx_start),
        .data   (tx_byte),
        .tx_out (line_out),
        .tx_oe  (line_oe),
        .done   (tx_done)
    );

    assign tmr_done = (timer == '0);

    // next state and command index
    always_comb begin
        state_d = state;
        idx_d   = idx;
        unique case (state)
            ST_WAIT_BYTE: begin
                if (rx_brk) begin
                    idx_d = 2'd0;
                end else if (rx_valid) begin
                    state_d = ST_ECHO_GAP;
                end
            end
            ST_ECHO_GAP: if (tmr_done) state_d = ST_ECHO;
            ST_ECHO: begin
                if (tx_done) begin
                    state_d = ST_WAIT_BYTE;
                    unique case (idx)
                        2'd0: idx_d = (cur_byte == OPC_READ || cur_byte == OPC_WRITE) ? 2'd1 : 2'd0;
                        2'd1: idx_d = 2'd2;
                        2'd2: begin
                            if (is_rd) begin
                                idx_d   = 2'd0;
                                state_d = ST_CANCEL;
                            end else begin
                                idx_d = 2'd3;
                            end
                        end
                        default: begin
                            idx_d   = 2'd0;
                            state_d = ST_CANCEL;
                        end
                    endcase
                end
            end
            ST_CANCEL: begin
                if (rx_brk)        state_d = ST_WAIT_BYTE;
                else if (tmr_done) state_d = is_rd ? ST_RET_GAP : ST_WRITE;
            end
            ST_WRITE:   state_d = ST_WAIT_BYTE;
            ST_RET_GAP: if (tmr_done) state_d = ST_FETCH;
            ST_FETCH:   state_d = ST_RET;
            ST_RET:     if (tx_done) state_d = ST_WAIT_BYTE;
            default:    state_d = ST_WAIT_BYTE;
        endcase
    end

    // state register, timer and captured command fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_WAIT_BYTE;
            timer    <= '0;
            idx      <= '0;
            is_rd    <= 1'b0;
            cur_byte <= '0;
            addr_hi  <= '0;
            addr_lo  <= '0;
            wdata    <= '0;
        end else begin
            state <= state_d;
            idx   <= idx_d;
            if (state_d != state) begin
                unique case (state_d)
                    ST_ECHO_GAP, ST_RET_GAP: timer <= GAP_LOAD;
                    ST_CANCEL:               timer <= WIN_LOAD;
                    default:                 timer <= '0;
                endcase
            end else if (!tmr_done) begin
                timer <= timer - 1'b1;
            end
            if (state == ST_WAIT_BYTE && rx_valid && !rx_brk) begin
                cur_byte <= rx_byte;
                unique case (idx)
                    2'd0:    is_rd   <= (rx_byte == OPC_READ);
                    2'd1:    addr_hi <= rx_byte;
                    2'd2:    addr_lo <= rx_byte;
                    default: wdata   <= rx_byte;
                endcase
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        rx_en    = (state == ST_WAIT_BYTE) || (state == ST_CANCEL);
        tx_start = ((state == ST_ECHO_GAP) && tmr_done) || (state == ST_FETCH);
        tx_byte  = (state == ST_FETCH) ? mem_rdata : cur_byte;
        mem_we   = (state == ST_WRITE);
        mem_re   = (state == ST_RET_GAP) && tmr_done;
    end

    assign mem_addr  = {addr_hi, addr_lo};
    assign mem_wdata = wdata;
endmodule

// File: rtl/swire_mon_chk.sv
module swire_mon_chk #(
    parameter int CLKS_PER_BIT = 8
) (
    input logic clk,
    input logic rst_n,
    input logic line_oe,
    input logic line_out,
    input logic mem_we,
    input logic mem_re
);
    localparam int MIN_QUIET = 2 * CLKS_PER_BIT;
    localparam int Q_W = $clog2(MIN_QUIET + 1);
    localparam logic [Q_W-1:0] Q_MAX = Q_W'(MIN_QUIET);

    logic [Q_W-1:0] quiet;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            quiet <= '0;
        else if (line_oe)      quiet <= '0;
        else if (quiet != Q_MAX) quiet <= quiet + 1'b1;
    end

    a_r9_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));
    a_r9_we_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);
    a_r9_re_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> !mem_re);
    a_r1_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_oe) |-> !line_out);
    a_r2_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_oe) |-> ($past(quiet) == Q_MAX));
    a_r3_re_then_tx: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> ##1 line_oe);
    a_r4_we_released: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !line_oe);
endmodule

bind swire_mon swire_mon_chk #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_oe  (line_oe),
    .line_out (line_out),
    .mem_we   (mem_we),
    .mem_re   (mem_re)
);

// File: tb/sim_swire_mon.sv
module sim_swire_mon;
    localparam int CPB = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_drv = 1'b1;
    logic        line_out, line_oe;
    logic        line;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        mem_we, mem_re;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    int we_cnt = 0, re_cnt = 0, we_cyc = 0;
    logic [15:0] we_addr, re_addr;
    logic [7:0]  we_data;

    always #10 clk = ~clk;
    assign line = line_oe ? line_out : host_drv;

    swire_mon #(.CLKS_PER_BIT(CPB)) u0 (
        .clk(clk), .rst_n(rst_n), .line_in(line), .line_out(line_out),
        .line_oe(line_oe), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] rd_f(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    always_ff @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_re) begin
            mem_rdata <= rd_f(mem_addr);
            re_cnt    <= re_cnt + 1;
            re_addr   <= mem_addr;
        end
        if (mem_we) begin
            we_cnt  <= we_cnt + 1;
            we_addr <= mem_addr;
            we_data <= mem_wdata;
            we_cyc  <= cyc;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        logic [9:0] fr = {1'b1, b, 1'b0};
        for (int i = 0; i < 10; i++) begin
            host_drv = fr[i];
            repeat (CPB) @(negedge clk);
        end
    endtask

    task automatic send_break(input int bits);
        host_drv = 1'b0;
        repeat (bits * CPB) @(negedge clk);
        host_drv = 1'b1;
    endtask

    // waits for a frame from the block and decodes it; w = cycles waited
    task automatic get_frame(input int limit, output logic [7:0] v, output bit ok, output int w);
        w = 0; ok = 0; v = '0;
        while (!line_oe && w < limit) begin
            @(negedge clk);
            w++;
        end
        if (line_oe) begin
            ok = 1;
            repeat (CPB / 2) @(negedge clk);
            if (line_out !== 1'b0) ok = 0;
            for (int i = 0; i < 8; i++) begin
                repeat (CPB) @(negedge clk);
                v[i] = line_out;
            end
            repeat (CPB) @(negedge clk);
            if (line_out !== 1'b1) ok = 0;
            while (line_oe) @(negedge clk);
        end
    endtask

    // sends one byte and checks its echo (R2, R1)
    task automatic send_echo(input logic [7:0] b);
        logic [7:0] v; bit ok; int w;
        send_byte(b);
        get_frame(40 * CPB, v, ok, w);
        chk(ok, "R1 echo framed", ok, 1);
        chk(v == b, "R2 echo value", v, b);
        chk(w >= CPB + CPB / 2 && w <= 3 * CPB, "R2 echo gap", w, 2 * CPB);
    endtask

    task automatic quiet_for(input int n, output int hi);
        hi = 0;
        repeat (n) begin
            @(negedge clk);
            if (line_oe) hi++;
        end
    endtask

    task automatic t_reset;
        chk(line_oe == 1'b0, "R10 oe at reset", line_oe, 0);
        chk(line_out == 1'b1, "R10 line released high", line_out, 1);
        chk(!mem_we && !mem_re, "R10 no strobes", {mem_we, mem_re}, 0);
    endtask

    task automatic t_read(input logic [15:0] a);
        logic [7:0] v; bit ok; int w; int r0 = re_cnt;
        send_echo(8'h4A);
        repeat (CPB) @(negedge clk);
        send_echo(a[15:8]);
        repeat (CPB) @(negedge clk);   // R8: one bit after echo
        send_echo(a[7:0]);
        get_frame(20 * CPB, v, ok, w);
        chk(ok, "R3 data frame", ok, 1);
        chk(v == rd_f(a), "R3 read data", v, rd_f(a));
        chk(w >= 13 * CPB && w <= 13 * CPB + 8, "R3 R5 return delay", w, 13 * CPB);
        chk(re_cnt == r0 + 1, "R3 one read strobe", re_cnt - r0, 1);
        chk(re_addr == a, "R3 read address", re_addr, a);
    endtask

    task automatic t_write(input logic [15:0] a, input logic [7:0] d);
        int w0 = we_cnt; int t0; int hi;
        send_echo(8'h49);
        repeat (CPB) @(negedge clk);
        send_echo(a[15:8]);
        repeat (CPB) @(negedge clk);
        send_echo(a[7:0]);
        repeat (CPB) @(negedge clk);
        send_echo(d);
        t0 = cyc;
        quiet_for(14 * CPB, hi);
        chk(hi == 0, "R4 no output after write", hi, 0);
        chk(we_cnt == w0 + 1, "R4 one write strobe", we_cnt - w0, 1);
        chk(we_addr == a, "R4 write address", we_addr, a);
        chk(we_data == d, "R4 write data", we_data, d);
        chk(we_cyc - t0 >= 11 * CPB - 2 && we_cyc - t0 <= 11 * CPB + 6,
            "R5 write after window", we_cyc - t0, 11 * CPB);
    endtask

    task automatic t_cancel(input bit rd);
        int w0 = we_cnt; int r0 = re_cnt; int hi;
        send_echo(rd ? 8'h4A : 8'h49);
        repeat (CPB) @(negedge clk);
        send_echo(8'h12);
        repeat (CPB) @(negedge clk);
        send_echo(8'h34);
        if (!rd) begin
            repeat (CPB) @(negedge clk);
            send_echo(8'hC3);
        end
        send_break(12);
        quiet_for(20 * CPB, hi);
        chk(hi == 0, "R5 no frame after cancel", hi, 0);
        chk(we_cnt == w0, "R5 no write after cancel", we_cnt - w0, 0);
        chk(re_cnt == r0, "R5 no read after cancel", re_cnt - r0, 0);
        t_read(16'h1234);
    endtask

    task automatic t_unknown;
        int w0 = we_cnt; int r0 = re_cnt; int hi;
        send_echo(8'h13);
        quiet_for(20 * CPB, hi);
        chk(hi == 0, "R7 silent after unknown", hi, 0);
        chk(we_cnt == w0 && re_cnt == r0, "R7 no access", (we_cnt - w0) + (re_cnt - r0), 0);
        t_read(16'h00FF);
    endtask

    task automatic t_break_mid;
        int r0 = re_cnt; int hi;
        send_echo(8'h4A);
        repeat (CPB) @(negedge clk);
        send_echo(8'h77);
        repeat (CPB) @(negedge clk);
        send_break(14);
        quiet_for(16 * CPB, hi);
        chk(hi == 0, "R6 break not echoed", hi, 0);
        chk(re_cnt == r0, "R6 no read after abort", re_cnt - r0, 0);
        t_read(16'hA55A);
    endtask

    initial begin
        wait (cyc >= 150000);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected 0", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        repeat (4 * CPB) @(negedge clk);
        t_reset;
        t_read(16'h0180);
        t_write(16'hBEEF, 8'h81);
        t_write(16'h0001, 8'h00);
        t_cancel(1'b0);
        t_cancel(1'b1);
        t_unknown;
        t_break_mid;
        t_read(16'hFFFF);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule